// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog

This block holds a small bank of independent watchdog timers behind a simple register bus. A timer that is not refreshed in time escalates through three expiry stages, and all three stages have the same length. The first expiry marks the timer's bit in a pending register, and that bit reaches the main processor as a maskable interrupt. The second expiry can send a one-cycle notification to a management controller. The third expiry raises a one-cycle system reset pulse. A 2-bit mode per timer picks how far the escalation may go. Software keeps a timer quiet by writing to its poke register, which refills the count and returns the timer to the first stage.

All timers share one prescaler. Each live count is 24 bits wide and is refilled from a 16-bit length with eight zero bits appended below it. The count steps down once per prescaler period. A stage therefore lasts (length x 256 + 1) prescaler periods, and the full time to reset is three times that.

Top module: `escal_wdog`

## Requirements
- R1: Register map, on 8-byte aligned addresses. Timer i's control word is at 8*i. Its fields are mode in [1:0], a management enable in [2], length in [19:4], the live count in [43:20] (read-only) and the stage in [49:48] (read-only). Pending is at 0x200, enable-clear at 0x210, enable-set at 0x218, and poke i at 0x10000 + 8*i. Unmapped addresses read as zero.
- R2: A refill loads the count with {length, 8'h00}. A refill happens on a poke, when the mode changes from 0 to non-zero, and after every expiry.
- R3: A running count steps down once per PRESCALE clocks, and a stage expires on the tick at which the count is already zero. One stage lasts exactly (length*256+1)*PRESCALE clocks.
- R4: Writing a value with bit 0 set to a poke address refills that timer and returns it to stage 0 (field value 0). Regular pokes prevent every expiry.
- R5: In mode 0 the count holds its value, the stage is 0 and no event is raised.
- R6: In mode 1, every expiry sets the pending bit and the timer stays in stage 0. It never raises a management or reset event.
- R7: In mode 2, the first expiry sets pending and the second can notify the management controller. After that the timer sits in stage 2 and raises nothing more.
- R8: In mode 3, the third expiry drives sys_rst high for exactly one clock, and the timer returns to stage 0.
- R9: A management pulse appears only when the timer's management enable bit is 1. When the bit is 0, the second expiry passes silently and the reset still follows one stage later.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle wins over the clear.
- R11: A 1 written to enable-set enables that timer's interrupt, and a 1 written to enable-clear disables it. Writing 0 changes nothing. Both addresses read back the enable mask.
- R12: host_irq is high exactly when some pending bit has its enable bit set.
- R13: After reset, all registers are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| host_irq | output | 1 | Maskable interrupt to the main processor |
| mgmt_irq | output | NUM_TMR | One-cycle management notification, one bit per timer |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The assertions require PRESCALE to be at least 2, so that prescaler ticks and reset pulses never fall on neighbouring cycles. They also require the bus inputs to be driven to known values whenever reset is released. They treat every bus_wr cycle as a complete write, so the properties on pending and enable bits depend on the write data being valid in that same cycle. The stimulus meets these conditions: it uses a prescale of 4, drives each write for exactly one clock between falling edges, keeps bus_wr low between accesses, and uses only aligned addresses. The one unmapped access is a read.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int LEN_W    = 16;
  localparam int CNT_W    = 24;
  localparam int FRAC_W   = CNT_W - LEN_W;
  localparam int DATA_W   = 64;
  localparam int MODE_LSB = 0;
  localparam int MGMT_BIT = 2;
  localparam int LEN_LSB  = 4;
  localparam int CNT_LSB  = 20;
  localparam int STG_LSB  = 48;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_IRQ      = 2'd1,
    MODE_IRQ_MGMT = 2'd2,
    MODE_FULL     = 2'd3
  } wdg_mode_e;

  typedef enum logic [1:0] {
    STG_ONE   = 2'd0,
    STG_TWO   = 2'd1,
    STG_THREE = 2'd2
  } wdg_stage_e;

  // count value after a refill: length in the upper bits, zero fraction
  function automatic logic [CNT_W-1:0] reload_count(input logic [LEN_W-1:0] len);
    return {len, {FRAC_W{1'b0}}};
  endfunction

  // stage that follows an expiry in the given mode
  function automatic wdg_stage_e next_stage(input wdg_mode_e m, input wdg_stage_e s);
    if (m == MODE_IRQ) return STG_ONE;
    case (s)
      STG_ONE: return STG_TWO;
      STG_TWO: return STG_THREE;
      default: return (m == MODE_FULL) ? STG_ONE : STG_THREE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(input wdg_mode_e m, input logic mg,
                                                 input logic [LEN_W-1:0] len,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input wdg_stage_e s);
    logic [DATA_W-1:0] r;
    r = '0;
    r[MODE_LSB +: 2]    = m;
    r[MGMT_BIT]         = mg;
    r[LEN_LSB +: LEN_W] = len;
    r[CNT_LSB +: CNT_W] = cnt;
    r[STG_LSB +: 2]     = s;
    return r;
  endfunction
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int unsigned PRESCALE = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);

  logic [PC_W-1:0] pc_q;

  assign tick = (pc_q == PC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_q <= '0;
    else if (tick) pc_q <= '0;
    else           pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_we,
  input  wdg_mode_e         cfg_mode,
  input  logic              cfg_mgmt,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              poke,
  output wdg_mode_e         mode_q,
  output logic              mgmt_en_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [CNT_W-1:0]  cnt_q,
  output wdg_stage_e        stage_q,
  output logic              first_exp,
  output logic              mgmt_pulse,
  output logic              rst_pulse
);
  logic run_tick;
  logic expire;
  logic mgmt_fire;
  logic rst_fire;

  assign run_tick  = tick && (mode_q != MODE_OFF);
  assign expire    = run_tick && (cnt_q == '0) && !cfg_we && !poke;
  assign first_exp = expire && (stage_q == STG_ONE);
  assign mgmt_fire = expire && (stage_q == STG_TWO) && mgmt_en_q && (mode_q != MODE_IRQ);
  assign rst_fire  = expire && (stage_q == STG_THREE) && (mode_q == MODE_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_OFF;
      mgmt_en_q  <= 1'b0;
      len_q      <= '0;
      cnt_q      <= '0;
      stage_q    <= STG_ONE;
      mgmt_pulse <= 1'b0;
      rst_pulse  <= 1'b0;
    end else begin
      mgmt_pulse <= mgmt_fire;
      rst_pulse  <= rst_fire;
      if (cfg_we) begin
        mode_q    <= cfg_mode;
        mgmt_en_q <= cfg_mgmt;
        len_q     <= cfg_len;
        if (cfg_mode == MODE_OFF) begin
          stage_q <= STG_ONE;
        end else if (mode_q == MODE_OFF) begin
          cnt_q   <= reload_count(cfg_len);
          stage_q <= STG_ONE;
        end
      end else if (poke) begin
        cnt_q   <= reload_count(len_q);
        stage_q <= STG_ONE;
      end else if (expire) begin
        cnt_q   <= reload_count(len_q);
        stage_q <= next_stage(mode_q, stage_q);
      end else if (run_tick) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_irq_ctl.sv
module wdg_irq_ctl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic         clr_we,
  input  logic         en_set_we,
  input  logic         en_clr_we,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] en_q,
  output logic         irq
);
  logic [N-1:0] clr_m;

  assign clr_m = clr_we ? mask : '0;
  assign irq   = |(pend_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_m) | set_v;
      if (en_set_we)      en_q <= en_q | mask;
      else if (en_clr_we) en_q <= en_q & ~mask;
    end
  end
endmodule

// File: rtl/escal_wdog.sv
module escal_wdog
  import wdg_pkg::*;
#(
  parameter int          NUM_TMR  = 4,
  parameter int unsigned PRESCALE = 1024,
  parameter int          ADDR_W   = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                host_irq,
  output logic [NUM_TMR-1:0]  mgmt_irq,
  output logic                sys_rst
);
  localparam int IDX_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(8 * NUM_TMR);
  localparam logic [ADDR_W-1:0] OFS_PEND  = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] OFS_ENCLR = ADDR_W'(32'h210);
  localparam logic [ADDR_W-1:0] OFS_ENSET = ADDR_W'(32'h218);
  localparam logic [ADDR_W-1:0] OFS_POKE  = ADDR_W'(32'h10000);

  logic                tick;
  logic                aligned, cfg_hit, poke_hit;
  logic                pend_wr, enset_wr, enclr_wr;
  logic [ADDR_W-1:0]   poke_ofs;
  logic [IDX_W-1:0]    cfg_slot, poke_slot;
  logic [NUM_TMR-1:0]  cfg_we_v, poke_v, first_exp_v, mgmt_en_v, rst_pulse_v;
  logic [NUM_TMR-1:0]  pend_v, en_v;
  logic [NUM_TMR*2-1:0]     mode_flat, stage_flat;
  logic [NUM_TMR*LEN_W-1:0] len_flat;
  logic [NUM_TMR*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]   cfg_rd_a [NUM_TMR];
  logic                wdata_unused;

  assign wdata_unused = ^{bus_wdata[DATA_W-1:LEN_LSB+LEN_W], bus_wdata[3]};

  // address decode
  assign aligned   = (bus_addr[2:0] == 3'b000);
  assign cfg_hit   = aligned && (bus_addr < SPAN);
  assign poke_ofs  = bus_addr - OFS_POKE;
  assign poke_hit  = aligned && (bus_addr >= OFS_POKE) && (poke_ofs < SPAN);
  assign cfg_slot  = bus_addr[3 +: IDX_W];
  assign poke_slot = poke_ofs[3 +: IDX_W];
  assign pend_wr   = bus_wr && (bus_addr == OFS_PEND);
  assign enset_wr  = bus_wr && (bus_addr == OFS_ENSET);
  assign enclr_wr  = bus_wr && (bus_addr == OFS_ENCLR);

  wdg_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    wdg_mode_e         mode_i;
    wdg_stage_e        stage_i;
    logic [LEN_W-1:0]  len_i;
    logic [CNT_W-1:0]  cnt_i;

    assign cfg_we_v[i] = bus_wr && cfg_hit && (cfg_slot == IDX_W'(i));
    assign poke_v[i]   = bus_wr && poke_hit && (poke_slot == IDX_W'(i)) && bus_wdata[0];

    wdg_timer u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cfg_we    (cfg_we_v[i]),
      .cfg_mode  (wdg_mode_e'(bus_wdata[MODE_LSB +: 2])),
      .cfg_mgmt  (bus_wdata[MGMT_BIT]),
      .cfg_len   (bus_wdata[LEN_LSB +: LEN_W]),
      .poke      (poke_v[i]),
      .mode_q    (mode_i),
      .mgmt_en_q (mgmt_en_v[i]),
      .len_q     (len_i),
      .cnt_q     (cnt_i),
      .stage_q   (stage_i),
      .first_exp (first_exp_v[i]),
      .mgmt_pulse(mgmt_irq[i]),
      .rst_pulse (rst_pulse_v[i])
    );

    assign mode_flat[i*2 +: 2]          = mode_i;
    assign stage_flat[i*2 +: 2]         = stage_i;
    assign len_flat[i*LEN_W +: LEN_W]   = len_i;
    assign cnt_flat[i*CNT_W +: CNT_W]   = cnt_i;
    assign cfg_rd_a[i] = pack_cfg(mode_i, mgmt_en_v[i], len_i, cnt_i, stage_i);
  end

  wdg_irq_ctl #(.N(NUM_TMR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (first_exp_v),
    .clr_we   (pend_wr),
    .en_set_we(enset_wr),
    .en_clr_we(enclr_wr),
    .mask     (bus_wdata[NUM_TMR-1:0]),
    .pend_q   (pend_v),
    .en_q     (en_v),
    .irq      (host_irq)
  );

  assign sys_rst = |rst_pulse_v;

  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) begin
      bus_rdata = cfg_rd_a[cfg_slot];
    end else if (bus_addr == OFS_PEND) begin
      bus_rdata[NUM_TMR-1:0] = pend_v;
    end else if ((bus_addr == OFS_ENCLR) || (bus_addr == OFS_ENSET)) begin
      bus_rdata[NUM_TMR-1:0] = en_v;
    end
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           pend_wr,
  input logic           enset_wr,
  input logic           enclr_wr,
  input logic [N-1:0]   wmask,
  input logic [N-1:0]   pend,
  input logic [N-1:0]   en,
  input logic [N-1:0]   first_exp_v,
  input logic [N-1:0]   mgmt_en_v,
  input logic [N-1:0]   mgmt_irq,
  input logic           sys_rst,
  input logic [N-1:0]   poke_v,
  input logic [N-1:0]   cfg_we_v,
  input logic [N*2-1:0] mode_flat,
  input logic [N*2-1:0] stage_flat,
  input logic [N*16-1:0] len_flat,
  input logic [N*24-1:0] cnt_flat
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R3
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst |=> !sys_rst); // R8
  AST_MGMT_GATED: assert property (@(posedge clk) disable iff (!rst_n) (mgmt_irq & ~$past(mgmt_en_v)) == '0); // R9
  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) ((pend & ~$past(pend)) & ~$past(first_exp_v)) == '0); // R6
  AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n) pend_wr |=> (pend & $past(wmask & ~first_exp_v)) == '0); // R10
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n) enset_wr |=> (en & $past(wmask)) == $past(wmask)); // R11
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n) enclr_wr |=> (en & $past(wmask)) == '0); // R11

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) poke_v[i] |=> (cnt_flat[i*24 +: 24] == {$past(len_flat[i*16 +: 16]), 8'h00}) && (stage_flat[i*2 +: 2] == 2'd0)); // R4
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((mode_flat[i*2 +: 2] == 2'd0) && !cfg_we_v[i] && !poke_v[i]) |=> $stable(cnt_flat[i*24 +: 24])); // R5
  end
endmodule

bind escal_wdog wdog_chk #(.N(NUM_TMR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .pend_wr    (pend_wr),
  .enset_wr   (enset_wr),
  .enclr_wr   (enclr_wr),
  .wmask      (bus_wdata[NUM_TMR-1:0]),
  .pend       (pend_v),
  .en         (en_v),
  .first_exp_v(first_exp_v),
  .mgmt_en_v  (mgmt_en_v),
  .mgmt_irq   (mgmt_irq),
  .sys_rst    (sys_rst),
  .poke_v     (poke_v),
  .cfg_we_v   (cfg_we_v),
  .mode_flat  (mode_flat),
  .stage_flat (stage_flat),
  .len_flat   (len_flat),
  .cnt_flat   (cnt_flat)
);

// File: tb/sim_escal_wdog.sv
module sim_escal_wdog;
  localparam int NT    = 4;
  localparam int PS    = 4;
  localparam int NSTEP = 257;          // length 1: 1*256 + 1 ticks per stage
  localparam int SL    = NSTEP * PS;   // clocks per stage

  typedef struct packed {
    logic [1:0]  op;    // 0 read, 1 write, 2 idle 40 clocks
    logic [16:0] addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 17'h00000, 64'h0, 64'h0, 8'd13},                              // R13 config 0
    '{2'd0, 17'h00200, 64'h0, 64'h0, 8'd13},                              // R13 pending
    '{2'd0, 17'h00218, 64'h0, 64'h0, 8'd13},                              // R13 enables
    '{2'd1, 17'h00218, 64'h5, 64'h0, 8'd11},
    '{2'd0, 17'h00218, 64'h0, 64'h5, 8'd11},                              // R11 set
    '{2'd0, 17'h00210, 64'h0, 64'h5, 8'd11},                              // R11 alias
    '{2'd1, 17'h00218, 64'h0, 64'h0, 8'd11},
    '{2'd0, 17'h00218, 64'h0, 64'h5, 8'd11},                              // R11 zero no-op
    '{2'd1, 17'h00210, 64'h1, 64'h0, 8'd11},
    '{2'd0, 17'h00218, 64'h0, 64'h4, 8'd11},                              // R11 clear
    '{2'd1, 17'h00210, 64'h0, 64'h0, 8'd11},
    '{2'd0, 17'h00210, 64'h0, 64'h4, 8'd11},                              // R11 zero no-op
    '{2'd1, 17'h00008, 64'h12344, 64'h0, 8'd1},
    '{2'd0, 17'h00008, 64'h0, 64'h12344, 8'd1},                           // R1 fields
    '{2'd1, 17'h10008, 64'h1, 64'h0, 8'd2},
    '{2'd0, 17'h00008, 64'h0, 64'h12340012344, 8'd2},                     // R2 refill
    '{2'd2, 17'h00000, 64'h0, 64'h0, 8'd5},
    '{2'd0, 17'h00008, 64'h0, 64'h12340012344, 8'd5},                     // R5 hold
    '{2'd1, 17'h00008, 64'h00030FFFFFF12344, 64'h0, 8'd1},
    '{2'd0, 17'h00008, 64'h0, 64'h12340012344, 8'd1},                     // R1 read-only
    '{2'd0, 17'h00100, 64'h0, 64'h0, 8'd1},                               // R1 unmapped
    '{2'd1, 17'h00210, 64'hF, 64'h0, 8'd11},
    '{2'd0, 17'h00218, 64'h0, 64'h0, 8'd11},
    '{2'd1, 17'h00008, 64'h0, 64'h0, 8'd5},
    '{2'd0, 17'h00008, 64'h0, 64'h12340000000, 8'd5}                      // R5 count kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [16:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  wire  [63:0] bus_rdata;
  wire         host_irq;
  wire  [NT-1:0] mgmt_irq;
  wire         sys_rst;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  escal_wdog #(.NUM_TMR(NT), .PRESCALE(PS)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .host_irq (host_irq),
    .mgmt_irq (mgmt_irq),
    .sys_rst  (sys_rst)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [63:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = '0;
  endtask

  function automatic logic sig(input int kind);
    case (kind)
      0: return host_irq;
      1: return |mgmt_irq;
      default: return sys_rst;
    endcase
  endfunction

  task automatic wait_ev(input int kind, input int lim, output int at, output int mg_seen);
    at = -1; mg_seen = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (kind != 1 && |mgmt_irq) mg_seen++;
      if (sig(kind)) begin at = cyc; break; end
    end
  endtask

  task automatic watch(input int n, output int evs);
    evs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (|mgmt_irq || sys_rst) evs++;
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R13 watchdog: actual %0d cycles expected under 150000", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    int e0, c1, c2, c3, mg, evs;

    // R13 outputs while in reset
    repeat (4) @(negedge clk);
    check("R13", "irq/mgmt/rst in reset", {host_irq, sys_rst, 4'(mgmt_irq)}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // register vectors
    for (int k = 0; k < NV; k++) begin
      case (TBL[k].op)
        2'd0: begin
          rd(TBL[k].addr, d);
          check($sformatf("R%0d", TBL[k].req), $sformatf("vector %0d read", k), d, TBL[k].exp);
        end
        2'd1: wr(TBL[k].addr, TBL[k].data);
        default: repeat (40) @(negedge clk);
      endcase
    end

    // mode 3 with management enabled on timer 0 (R2, R3, R8)
    wr(17'h00218, 64'h1);
    wr(17'h00000, 64'h17);
    e0 = cyc;
    rd(17'h00000, d);
    check("R2", "refill on start", d, 64'h10000017);
    wait_ev(0, 2 * SL, c1, mg);
    check("R3", "first stage in window", ((c1 - e0) >= (NSTEP - 1) * PS + 1) && ((c1 - e0) <= SL), 1);
    wait_ev(1, 2 * SL, c2, mg);
    check("R3", "second stage length", c2 - c1, SL);
    @(negedge clk);
    check("R7", "mgmt pulse width", 4'(mgmt_irq), 0);
    wait_ev(2, 2 * SL, c3, mg);
    check("R8", "third stage to reset", c3 - c2, SL);
    rd(17'h00000, d);
    check("R8", "stage back to 0", d[49:48], 0);
    @(negedge clk);
    check("R8", "reset one cycle", sys_rst, 0);
    wr(17'h00000, 64'h0);
    rd(17'h00200, d);
    check("R6", "pending after first expiry", d, 64'h1);
    check("R12", "host irq with enable", host_irq, 1);
    wr(17'h00200, 64'h0);
    rd(17'h00200, d);
    check("R10", "write 0 keeps pending", d, 64'h1);
    wr(17'h00200, 64'h1);
    rd(17'h00200, d);
    check("R10", "write 1 clears pending", d, 64'h0);
    check("R12", "host irq after clear", host_irq, 0);

    // mode 2 with management on timer 2 (R7)
    wr(17'h00210, 64'hF);
    wr(17'h00218, 64'h4);
    wr(17'h00010, 64'h16);
    wait_ev(0, 2 * SL, c1, mg);
    wait_ev(1, 2 * SL, c2, mg);
    check("R7", "mgmt after one stage", c2 - c1, SL);
    check("R7", "mgmt on timer 2", 4'(mgmt_irq), 4'h4);
    watch(2 * SL + 50, evs);
    check("R7", "no later events", evs, 0);
    rd(17'h00010, d);
    check("R7", "stage held at 2", d[49:48], 2);
    wr(17'h00010, 64'h0);
    wr(17'h00200, 64'h4);
    rd(17'h00200, d);
    check("R10", "pending cleared", d, 64'h0);

    // mode 3 without management on timer 3 (R9)
    wr(17'h00210, 64'hF);
    wr(17'h00218, 64'h8);
    wr(17'h00018, 64'h13);
    wait_ev(0, 2 * SL, c1, mg);
    wait_ev(2, 3 * SL, c3, mg);
    check("R9", "reset two stages after irq", c3 - c1, 2 * SL);
    check("R9", "no mgmt pulse", mg, 0);
    wr(17'h00018, 64'h0);
    wr(17'h00200, 64'h8);
    wr(17'h00210, 64'hF);

    // mode 1, length 0, masked (R6, R12)
    wr(17'h00008, 64'h1);
    watch(10 * PS, evs);
    check("R6", "no mgmt or reset in mode 1", evs, 0);
    rd(17'h00200, d);
    check("R6", "pending set in mode 1", d, 64'h2);
    check("R12", "masked host irq", host_irq, 0);
    rd(17'h00008, d);
    check("R6", "stage stays 0", d[49:48], 0);
    wr(17'h00218, 64'h2);
    check("R12", "unmasked host irq", host_irq, 1);
    wr(17'h00008, 64'h0);
    wr(17'h00200, 64'h2);
    wr(17'h00210, 64'hF);

    // steady poking (R4)
    wr(17'h00000, 64'h13);
    evs = 0;
    for (int k = 0; k < 8; k++) begin
      int e;
      watch(600, e);
      evs += e;
      wr(17'h10000, 64'h1);
    end
    rd(17'h00000, d);
    check("R4", "refill and stage 0 after poke", d, 64'h10000013);
    rd(17'h00200, d);
    check("R4", "no expiry while poked", d, 64'h0);
    check("R4", "no events while poked", evs, 0);
    wr(17'h00000, 64'h0);

    summary();
    $finish;
  end
endmodule